// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block holds a second wake-style alarm made of six BCD time fields and compares it against the running calendar time supplied by a separate clock core. The comparison runs only on the cycle in which the clock core signals a seconds update. On an equal result the block latches an alarm flag, which can raise an interrupt. If software has also handed the power-enable pin to the alarm logic, the pin that feeds an external power-management IC is pulled low.

Software loads the six alarm fields through a simple word-addressed write bus with byte strobes. A typical sequence is to target a moment two seconds ahead, so that every field is in place before the next seconds update. Software then gives the pin to the alarm logic and arms the alarm event with a full-word write to the interrupt-enable register.

A two-state machine owns the pin. In `ST_POWERED` the pin is high. The transition to `ST_SHUTDOWN` (pin low) is taken on a qualifying match with both control bits set. The transition back to `ST_POWERED` is taken only on a power-on event input or a reset.

Register map (byte addresses):
- Alarm fields at 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). Each field is 8-bit BCD in byte lane 0.
- Interrupt-enable register at 0x18, with the alarm-event arm bit at bit 4.
- Status register at 0x1C, with the alarm flag at bit 7.
- Power-control register at 0x20, with the pin-ownership bit at bit 16.

Top module: `pwr_alarm_ctl`

## Requirements
- R1: After reset `pwr_en` is 1, `irq` is 0, and every register (alarm fields, interrupt enable, status, power control) reads 0.
- R2: A write with `wr_be[0]` set to address 4*i (i = 0 seconds … 5 year) stores `wr_data[7:0]` into alarm field i. The field reads back in `rd_data[7:0]`, with the upper bits 0.
- R3: On a cycle with `tick`=1 where all six fields of `time_bcd` (field i at bits [8i+7:8i]) equal the alarm fields, status bit 7 (address 0x1C) is 1 from the next cycle. This happens whatever the enable bits are. `irq` is 1 exactly when status bit 7 and interrupt-enable bit 4 are both 1.
- R4: Writing 1 to status bit 7 (with `wr_be[0]`) clears it. Writing 0 to that bit leaves it unchanged.
- R5: The interrupt-enable register at 0x18 updates only on a write with `wr_be` = 4'hF. A write with any other strobe pattern leaves it unchanged.
- R6: `pwr_en` goes to 0 in the cycle after a tick-match if power-control bit 16 and interrupt-enable bit 4 were both 1 at that match. With bit 16 clear, a match leaves `pwr_en` at 1.
- R7: Once `pwr_en` is 0 it stays 0 through later ticks and time changes. It returns to 1 in the cycle after `pwr_on_evt` is 1, or on reset.
- R8: No match is recognised on a cycle without `tick`, and no match is recognised when any single field differs from its alarm field.
- R9: Power-control bit 16 (address 0x20) is written by any write with `wr_be[2]` set and reads back at bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Combinational read data |
| time_bcd | input | 48 | Current BCD time from the clock core, seconds in the low byte, year in the high byte |
| tick | input | 1 | One-cycle pulse marking a seconds update |
| pwr_on_evt | input | 1 | Power-on event that restores the pin |
| pwr_en | output | 1 | Power-enable pin to the external power IC, low means off |
| irq | output | 1 | Alarm interrupt |

## Verification
The comparator is exercised with the exact alarm time and then with six patterns that each differ from the alarm in one field only, plus an all-zero time. This shows that every field takes part in the match and that no field is ignored.

Directed sequences then separate the flag-only outcome (pin not owned) from the shutdown outcome (pin owned and armed). They check that a shutdown persists across later ticks with moving time, and that only a power-on event or reset ends it. Partial-strobe writes to the enable register, and zero writes to the status flag, confirm that those writes leave the state unchanged.

// File: rtl/pwroff_pkg.sv
`timescale 1ns/1ps
package pwroff_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 8;
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] A_IEN  = 8'h18;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h1C;
    localparam logic [ADDR_W-1:0] A_PCTL = 8'h20;

    localparam int IEN_BIT  = 4;
    localparam int STAT_BIT = 7;
    localparam int PCTL_BIT = 16;

    typedef enum logic {
        ST_POWERED  = 1'b0,
        ST_SHUTDOWN = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/pao_regs.sv
`timescale 1ns/1ps
module pao_regs
    import pwroff_pkg::*;
#(
    parameter int NF     = NUM_FIELDS,
    parameter int FW     = FIELD_W,
    parameter int AW     = ADDR_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hit,
    output logic [NF*FW-1:0]  alarm_bcd,
    output logic              ien_arm,
    output logic              pctl_own,
    output logic              stat_alarm
);
    localparam int NBE = DATA_W / 8;

    logic full_word;
    assign full_word = (wr_be == {NBE{1'b1}});

    // Alarm field storage, one byte register per field
    for (genvar i = 0; i < NF; i++) begin : g_alm
        logic [FW-1:0] fld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fld_q <= '0;
            else if (wr_en && wr_be[0] && wr_addr == AW'(i * 4))
                fld_q <= wr_data[FW-1:0];
        end
        assign alarm_bcd[i*FW +: FW] = fld_q;
    end

    // Interrupt enable: whole-word writes only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ien_arm <= 1'b0;
        else if (wr_en && full_word && wr_addr == A_IEN)
            ien_arm <= wr_data[IEN_BIT];
    end

    // Pin ownership bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pctl_own <= 1'b0;
        else if (wr_en && wr_be[PCTL_BIT/8] && wr_addr == A_PCTL)
            pctl_own <= wr_data[PCTL_BIT];
    end

    // Alarm flag: a match sets it and wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_alarm <= 1'b0;
        else if (hit)
            stat_alarm <= 1'b1;
        else if (wr_en && wr_be[0] && wr_addr == A_STAT && wr_data[STAT_BIT])
            stat_alarm <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NF; i++) begin
            if (rd_addr == AW'(i * 4))
                rd_data[FW-1:0] = alarm_bcd[i*FW +: FW];
        end
        if (rd_addr == A_IEN)  rd_data[IEN_BIT]  = ien_arm;
        if (rd_addr == A_STAT) rd_data[STAT_BIT] = stat_alarm;
        if (rd_addr == A_PCTL) rd_data[PCTL_BIT] = pctl_own;
    end
endmodule

// File: rtl/pao_match.sv
`timescale 1ns/1ps
module pao_match #(
    parameter int NF = 6,
    parameter int FW = 8
) (
    input  logic [NF*FW-1:0] time_bcd,
    input  logic [NF*FW-1:0] alarm_bcd,
    input  logic             tick,
    output logic             hit
);
    logic [NF-1:0] fld_eq;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        assign fld_eq[i] = (time_bcd[i*FW +: FW] == alarm_bcd[i*FW +: FW]);
    end

    assign hit = tick && (&fld_eq);
endmodule

// File: rtl/pao_fsm.sv
`timescale 1ns/1ps
module pao_fsm
    import pwroff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic armed,
    input  logic pwr_on_evt,
    output logic pwr_en
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_POWERED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERED:  if (hit && armed) state_d = ST_SHUTDOWN;
            ST_SHUTDOWN: if (pwr_on_evt)   state_d = ST_POWERED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_POWERED:  pwr_en = 1'b1;
            ST_SHUTDOWN: pwr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_alarm_ctl.sv
`timescale 1ns/1ps
module pwr_alarm_ctl
    import pwroff_pkg::*;
#(
    parameter int NF     = NUM_FIELDS,
    parameter int FW     = FIELD_W,
    parameter int AW     = ADDR_W,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [AW-1:0]       rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NF*FW-1:0]    time_bcd,
    input  logic                tick,
    input  logic                pwr_on_evt,
    output logic                pwr_en,
    output logic                irq
);
    logic [NF*FW-1:0] alarm_bcd;
    logic             hit;
    logic             ien_arm;
    logic             pctl_own;
    logic             stat_alarm;

    pao_match #(.NF(NF), .FW(FW)) u_match (
        .time_bcd  (time_bcd),
        .alarm_bcd (alarm_bcd),
        .tick      (tick),
        .hit       (hit)
    );

    pao_regs #(.NF(NF), .FW(FW), .AW(AW), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .hit        (hit),
        .alarm_bcd  (alarm_bcd),
        .ien_arm    (ien_arm),
        .pctl_own   (pctl_own),
        .stat_alarm (stat_alarm)
    );

    pao_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .armed      (ien_arm && pctl_own),
        .pwr_on_evt (pwr_on_evt),
        .pwr_en     (pwr_en)
    );

    assign irq = stat_alarm && ien_arm;
endmodule

// File: rtl/pwr_alarm_chk.sv
`timescale 1ns/1ps
module pwr_alarm_chk
    import pwroff_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NBE = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [NBE-1:0] wr_be,
    input logic           tick,
    input logic           pwr_on_evt,
    input logic           pwr_en,
    input logic           ien_arm,
    input logic           pctl_own,
    input logic           stat_alarm
);
    AST_PIN_DROP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(tick && ien_arm && pctl_own)); // R6

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !pwr_on_evt) |=> !pwr_en); // R7

    AST_POWER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && pwr_on_evt) |=> pwr_en); // R7

    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_alarm) |-> $past(tick)); // R8

    AST_IEN_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ien_arm) |-> $past(wr_en && wr_addr == A_IEN && (&wr_be))); // R5
endmodule

bind pwr_alarm_ctl pwr_alarm_chk #(.AW(AW), .NBE(DATA_W/8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_be      (wr_be),
    .tick       (tick),
    .pwr_on_evt (pwr_on_evt),
    .pwr_en     (pwr_en),
    .ien_arm    (ien_arm),
    .pctl_own   (pctl_own),
    .stat_alarm (stat_alarm)
);

// File: tb/tb_pwr_alarm_ctl.sv
`timescale 1ns/1ps
module tb_pwr_alarm_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [47:0] time_bcd = '0;
    logic        tick = 1'b0;
    logic        pwr_on_evt = 1'b0;
    logic        pwr_en;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwr_alarm_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
        .time_bcd(time_bcd), .tick(tick), .pwr_on_evt(pwr_on_evt),
        .pwr_en(pwr_en), .irq(irq)
    );

    localparam logic [47:0] ALM = 48'h99_12_31_23_58_59;
    // {time, expect_match}
    localparam logic [48:0] VEC [8] = '{
        {48'h99_12_31_23_58_59, 1'b1},
        {48'h99_12_31_23_58_58, 1'b0},
        {48'h99_12_31_23_57_59, 1'b0},
        {48'h99_12_31_22_58_59, 1'b0},
        {48'h99_12_30_23_58_59, 1'b0},
        {48'h99_11_31_23_58_59, 1'b0},
        {48'h98_12_31_23_58_59, 1'b0},
        {48'h00_00_00_00_00_00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic tick_at(input logic [47:0] t);
        @(negedge clk);
        time_bcd = t; tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 pwr_en", {31'b0, pwr_en}, 32'd1);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        for (int a = 0; a <= 8'h20; a += 4) begin
            rd(8'(a), d);
            chk("R1 register zero", d, 32'd0);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2: alarm field load and readback
        for (int i = 0; i < 6; i++) wr(8'(i * 4), {24'hABCDEF, ALM[i*8 +: 8]}, 4'h1);
        for (int i = 0; i < 6; i++) begin
            rd(8'(i * 4), d);
            chk("R2 alarm field", d, {24'b0, ALM[i*8 +: 8]});
        end

        // R5: partial-strobe write to enable ignored, full word accepted
        wr(8'h18, 32'h0000_0010, 4'h1);
        rd(8'h18, d);
        chk("R5 partial write ignored", d, 32'h0);
        wr(8'h18, 32'h0000_0010, 4'hF);
        rd(8'h18, d);
        chk("R5 full write", d, 32'h10);

        // R3/R8: vector table walk
        foreach (VEC[v]) begin
            wr(8'h1C, 32'h80, 4'h1);
            tick_at(VEC[v][48:1]);
            rd(8'h1C, d);
            chk("R8 R3 table flag", d, VEC[v][0] ? 32'h80 : 32'h0);
            chk("R3 table irq", {31'b0, irq}, {31'b0, VEC[v][0]});
            chk("R6 pin not owned", {31'b0, pwr_en}, 32'd1);
        end

        // R4: write zero keeps flag, write one clears
        wr(8'h1C, 32'h0, 4'h1);
        tick_at(ALM);
        wr(8'h1C, 32'h0, 4'h1);
        rd(8'h1C, d);
        chk("R4 zero write keeps", d, 32'h80);
        wr(8'h1C, 32'h80, 4'h1);
        rd(8'h1C, d);
        chk("R4 one write clears", d, 32'h0);
        chk("R3 irq follows flag", {31'b0, irq}, 32'd0);

        // R8: equal time without tick
        @(negedge clk); time_bcd = ALM;
        repeat (3) @(posedge clk); #1;
        rd(8'h1C, d);
        chk("R8 no tick no flag", d, 32'h0);

        // R9: pin ownership
        wr(8'h20, 32'h0001_0000, 4'h4);
        rd(8'h20, d);
        chk("R9 ownership bit", d, 32'h0001_0000);

        // R6: owned and armed match drops pin
        tick_at(ALM);
        chk("R6 pin low after match", {31'b0, pwr_en}, 32'd0);

        // R7: stays low across later ticks
        tick_at(48'h99_12_31_23_59_00);
        tick_at(ALM);
        chk("R7 stays low", {31'b0, pwr_en}, 32'd0);
        @(negedge clk); pwr_on_evt = 1'b1;
        @(posedge clk); #1; pwr_on_evt = 1'b0;
        chk("R7 power-on restores", {31'b0, pwr_en}, 32'd1);

        // R6: enable cleared blocks shutdown
        wr(8'h18, 32'h0, 4'hF);
        tick_at(ALM);
        chk("R6 no arm no drop", {31'b0, pwr_en}, 32'd1);

        // R7: reset restores
        wr(8'h18, 32'h10, 4'hF);
        tick_at(ALM);
        chk("R7 dropped again", {31'b0, pwr_en}, 32'd0);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R7 reset restores", {31'b0, pwr_en}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule